// File: doc/BRIEF.md
# Tone Transceiver Host Register and Burst Sequencer

This block sits between a host processor and the tone synthesis and tone detection paths of a telephone signalling transceiver. The host reaches it over a small synchronous bus: chip select, a read/write line, a single register-select line and a 4-bit data path. Behind that bus sit a transmit code register, a receive code register, a status register and two control registers. The two control registers share one write address. A one-shot redirect bit steers the next control write to the second register.

On the transmit side, the block drives a tone enable, the 4-bit tone code and the single-tone and column-group selects to the synthesiser. In continuous mode the tone runs for as long as the host keeps the output enabled. In burst mode a write to the transmit register starts a timed tone interval followed by an equal silent interval. After that, the block flags that it is ready and can interrupt the host. Call-progress mode doubles both intervals.

On the receive side, a validated-tone strobe from the detector latches the decoded code and can raise the interrupt. A test selection places the inverted delayed-steering signal from the detector on the interrupt pin.

Top module: `tone_host_ctrl`

## Requirements
- R1: After reset, both control registers hold zero, tone_en is 0, irq_n is 1, the receive register reads 0, and status reads 4'b0010 (bit1 = transmitter ready). Reset is asynchronous and active low. Its release is synchronised over two clock edges.
- R2: A write with rs=1 and data bit 3 set lands in control A and arms a redirect. Only the following rs=1 write lands in control B; after that, writes at rs=1 return to control A.
- R3: Control A bit 0 is the tone output enable. With control B bit 0 = 1 (continuous mode), tone_en equals that bit, and every rs=0 write loads tone_code.
- R4: With control B bit 0 = 0 (burst mode), control A bit 1 = 0 and control A bit 0 = 1, an accepted transmit write holds tone_en high for exactly BURST_TICKS cycles. A silent gap of BURST_TICKS cycles follows, and then the ready event occurs.
- R5: With control A bit 1 = 1 (call-progress), both the tone interval and the gap last 2*BURST_TICKS cycles.
- R6: A transmit write that arrives during a burst's tone or gap is ignored: tone_code and the timing are unchanged.
- R7: Status bit 1 (ready) is 0 from the accepted burst write until the gap ends.
- R8: Control A bit 2 enables interrupts. At the end of a gap, status bit 3 (transmit event) is set, and if interrupts are enabled, status bit 0 is set and irq_n goes low. With bit 2 = 0, irq_n stays high.
- R9: An rx_valid pulse loads rx_code into the receive register (read at rs=0) and sets status bit 2. If interrupts are enabled, it also sets status bit 0 and drives irq_n low.
- R10: A status read (rs=1, rw=1) clears status bits 0, 2 and 3 and releases irq_n. An event in the same cycle as the read takes precedence.
- R11: With control B bit 1 = 1 and control A bit 1 = 0, irq_n equals the inverse of rx_steer. With control A bit 1 = 1, the test selection has no effect.
- R12: tone_single follows control B bit 2 (1 = single tone) and tone_column follows control B bit 3 (1 = column group, 0 = row group).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, one access per clock while low |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 1 | Register select: 0 = tx/rx code, 1 = control/status |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data, valid while a read is selected, else 0 |
| rx_valid | input | 1 | One-cycle strobe for a validated received tone |
| rx_code | input | 4 | Code of the validated tone |
| rx_steer | input | 1 | Delayed steering level from the detector |
| tone_en | output | 1 | Tone generator enable |
| tone_code | output | 4 | Code of the tone pair to generate |
| tone_single | output | 1 | 1 = single-tone output |
| tone_column | output | 1 | 1 = column-group tone in single mode |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Continuous-mode sweeps over all 16 transmit codes and all 16 control B values separate correct register steering from a redirect that sticks or never arms. Timed bursts are measured cycle by cycle in the normal case and in call-progress mode, so that an off-by-one terminal count or a missing doubling shows as a wrong interval count. A transmit write issued mid-burst, and bursts run with interrupts enabled and disabled, separate accepted from ignored writes and gated from ungated interrupts. Received-code sweeps and the test-mode routing, tried under both tone and call-progress modes, cover the receive path and the interrupt pin's two sources.

// File: rtl/tone_host_pkg.sv
package tone_host_pkg;
  localparam int REG_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TONE = 2'd1,
    PH_GAP  = 2'd2
  } burst_phase_e;

  // control A: bit3 redirect, bit2 irq enable, bit1 call-progress, bit0 tone out
  typedef struct packed {
    logic redir;
    logic irq_en;
    logic cp_mode;
    logic tone_out;
  } ctrl_a_t;

  // control B: bit3 column, bit2 single, bit1 test, bit0 continuous (not burst)
  typedef struct packed {
    logic column;
    logic single;
    logic test;
    logic cont;
  } ctrl_b_t;
endpackage

// File: rtl/tone_host_regs.sv
module tone_host_regs
  import tone_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  output ctrl_a_t          ctrl_a,
  output ctrl_b_t          ctrl_b
);
  ctrl_a_t a_q, a_d;
  ctrl_b_t b_q, b_d;
  logic    redir_q, redir_d;

  always_comb begin
    a_d     = a_q;
    b_d     = b_q;
    redir_d = redir_q;
    if (wr_ctl) begin
      if (redir_q) begin
        b_d     = ctrl_b_t'(wdata);
        redir_d = 1'b0;
      end else begin
        a_d     = ctrl_a_t'(wdata);
        redir_d = wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      redir_q <= 1'b0;
    end else if (wr_ctl) begin
      a_q     <= a_d;
      b_q     <= b_d;
      redir_q <= redir_d;
    end
  end

  assign ctrl_a = a_q;
  assign ctrl_b = b_q;

  // R2
  redir_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && redir_q) |=> (!redir_q && $stable(a_q)));
endmodule

// File: rtl/tone_host_burst.sv
module tone_host_burst
  import tone_host_pkg::*;
#(
  parameter int BURST_TICKS = 1000,
  localparam int CNT_W = $clog2(2*BURST_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_mode,
  input  logic             cp_mode,
  input  logic             tx_wr,
  input  logic [REG_W-1:0] tx_wdata,
  output logic [REG_W-1:0] tx_code,
  output logic             tone_active,
  output logic             ready,
  output logic             ready_evt
);
  localparam logic [CNT_W-1:0] LEN_BASE = CNT_W'(BURST_TICKS);

  burst_phase_e     phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [REG_W-1:0] code_q, code_d;
  logic             ready_q, ready_d;
  logic             accept, last;

  assign accept = tx_wr && (!burst_mode || phase_q == PH_IDLE);
  assign last   = (cnt_q == len_q - 1'b1);

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    len_d     = len_q;
    code_d    = code_q;
    ready_d   = ready_q;
    ready_evt = 1'b0;
    if (accept) code_d = tx_wdata;
    if (!burst_mode) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      ready_d = 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          phase_d = PH_TONE;
          cnt_d   = '0;
          len_d   = cp_mode ? (LEN_BASE << 1) : LEN_BASE;
          ready_d = 1'b0;
        end
        PH_TONE: if (last) begin
          phase_d = PH_GAP;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
        PH_GAP: if (last) begin
          phase_d   = PH_IDLE;
          cnt_d     = '0;
          ready_d   = 1'b1;
          ready_evt = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= LEN_BASE;
      code_q  <= '0;
      ready_q <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      code_q  <= code_d;
      ready_q <= ready_d;
    end
  end

  assign tx_code     = code_q;
  assign tone_active = (phase_q == PH_TONE);
  assign ready       = ready_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (cnt_q < len_q));
  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> !ready_q);
  // R6
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && phase_q != PH_IDLE && tx_wr) |=> $stable(code_q));
endmodule

// File: rtl/tone_host_irq.sv
module tone_host_irq
  import tone_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_evt,
  input  logic             ready,
  input  logic             rx_valid,
  input  logic [REG_W-1:0] rx_code,
  input  logic             irq_en,
  input  logic             stat_rd,
  input  logic             test_sel,
  input  logic             rx_steer,
  output logic [REG_W-1:0] rx_data,
  output logic [REG_W-1:0] status,
  output logic             irq_n
);
  logic             irq_q, irq_d;
  logic             rxe_q, rxe_d;
  logic             txe_q, txe_d;
  logic [REG_W-1:0] rxd_q;

  always_comb begin
    irq_d = irq_q;
    rxe_d = rxe_q;
    txe_d = txe_q;
    if (stat_rd) begin
      irq_d = 1'b0;
      rxe_d = 1'b0;
      txe_d = 1'b0;
    end
    if (ready_evt) begin
      txe_d = 1'b1;
      if (irq_en) irq_d = 1'b1;
    end
    if (rx_valid) begin
      rxe_d = 1'b1;
      if (irq_en) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rxe_q <= 1'b0;
      txe_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      rxe_q <= rxe_d;
      txe_q <= txe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rxd_q <= '0;
    else if (rx_valid) rxd_q <= rx_code;
  end

  assign rx_data = rxd_q;
  assign status  = {txe_q, rxe_q, ready, irq_q};
  assign irq_n   = test_sel ? ~rx_steer : ~irq_q;

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ready_evt && !rx_valid) |=> !irq_q);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(irq_en && (ready_evt || rx_valid)));
endmodule

// File: rtl/tone_host_ctrl.sv
module tone_host_ctrl
  import tone_host_pkg::*;
#(
  parameter int BURST_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rw,
  input  logic       rs,
  input  logic [3:0] wdata,
  output logic [3:0] rdata,
  input  logic       rx_valid,
  input  logic [3:0] rx_code,
  input  logic       rx_steer,
  output logic       tone_en,
  output logic [3:0] tone_code,
  output logic       tone_single,
  output logic       tone_column,
  output logic       irq_n
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic             wr_ctl, wr_tx, rd_stat;
  ctrl_a_t          ctrl_a;
  ctrl_b_t          ctrl_b;
  logic             tone_active, ready, ready_evt;
  logic [REG_W-1:0] rx_data, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign wr_ctl  = !cs_n && !rw && rs;
  assign wr_tx   = !cs_n && !rw && !rs;
  assign rd_stat = !cs_n && rw && rs;

  tone_host_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_ctl (wr_ctl),
    .wdata  (wdata),
    .ctrl_a (ctrl_a),
    .ctrl_b (ctrl_b)
  );

  tone_host_burst #(.BURST_TICKS(BURST_TICKS)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .burst_mode  (!ctrl_b.cont),
    .cp_mode     (ctrl_a.cp_mode),
    .tx_wr       (wr_tx),
    .tx_wdata    (wdata),
    .tx_code     (tone_code),
    .tone_active (tone_active),
    .ready       (ready),
    .ready_evt   (ready_evt)
  );

  tone_host_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ready_evt (ready_evt),
    .ready     (ready),
    .rx_valid  (rx_valid),
    .rx_code   (rx_code),
    .irq_en    (ctrl_a.irq_en),
    .stat_rd   (rd_stat),
    .test_sel  (ctrl_b.test && !ctrl_a.cp_mode),
    .rx_steer  (rx_steer),
    .rx_data   (rx_data),
    .status    (status),
    .irq_n     (irq_n)
  );

  always_comb begin
    rdata = '0;
    if (!cs_n && rw) rdata = rs ? status : rx_data;
  end

  assign tone_en     = ctrl_a.tone_out && (ctrl_b.cont || tone_active);
  assign tone_single = ctrl_b.single;
  assign tone_column = ctrl_b.column;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n_i |-> (tone_en == 1'b0));
endmodule

// File: tb/tb_tone_host_ctrl.sv
`timescale 1ns/100ps
module tb_tone_host_ctrl;
  localparam int L = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, rw, rs;
  logic [3:0] wdata;
  logic [3:0] rdata;
  logic       rx_valid;
  logic [3:0] rx_code;
  logic       rx_steer;
  logic       tone_en;
  logic [3:0] tone_code;
  logic       tone_single, tone_column, irq_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tone_host_ctrl #(.BURST_TICKS(L)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .rs(rs), .wdata(wdata),
    .rdata(rdata), .rx_valid(rx_valid), .rx_code(rx_code), .rx_steer(rx_steer),
    .tone_en(tone_en), .tone_code(tone_code), .tone_single(tone_single),
    .tone_column(tone_column), .irq_n(irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [3:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; rs = sel; wdata = d;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic sel, output logic [3:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; rs = sel;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b0;
  endtask

  task automatic set_b(input logic [3:0] v);
    bus_wr(1'b1, 4'b1000);
    bus_wr(1'b1, v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // issue a burst write and measure tone-on cycles and gap until irq_n falls
  task automatic measure(input logic [3:0] code, output int on_c, output int gap_c);
    on_c = 0; gap_c = 0;
    bus_wr(1'b0, code);
    while (tone_en && on_c < 1000) begin on_c++; @(negedge clk); end
    while (irq_n && gap_c < 1000) begin gap_c++; @(negedge clk); end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] r;
    int on_c, gap_c;
    cs_n = 1'b1; rw = 1'b0; rs = 1'b0; wdata = '0;
    rx_valid = 1'b0; rx_code = '0; rx_steer = 1'b0;
    rst_n = 1'b0;
    idle(3);
    check("R1 tone_en", tone_en, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 single", tone_single, 0);
    rst_n = 1'b1;
    idle(4);
    bus_rd(1'b1, r); check("R1 status", r, 4'b0010);
    bus_rd(1'b0, r); check("R1 rx data", r, 0);

    // R2 / R12: redirect into B, then back to A
    bus_wr(1'b1, 4'b1000);
    bus_wr(1'b1, 4'b1101);
    check("R2 single via B", tone_single, 1);
    check("R12 column", tone_column, 1);
    check("R2 tone_en untouched", tone_en, 0);
    bus_wr(1'b1, 4'b0001);
    check("R2 back to A single kept", tone_single, 1);
    check("R3 continuous tone_en", tone_en, 1);

    // R3: sweep transmit codes in continuous mode
    for (int c = 0; c < 16; c++) begin
      bus_wr(1'b0, 4'(c));
      check("R3 tone_code", tone_code, c);
      check("R3 tone_en held", tone_en, 1);
    end
    bus_wr(1'b1, 4'b0000);
    check("R3 tone_en off", tone_en, 0);

    // R12: sweep control B
    for (int v = 0; v < 16; v++) begin
      set_b(4'(v));
      check("R12 single", tone_single, (v >> 2) & 1);
      check("R12 column", tone_column, (v >> 3) & 1);
    end
    set_b(4'b0000);

    // R4 / R8: burst with interrupts
    bus_wr(1'b1, 4'b0101);
    measure(4'd9, on_c, gap_c);
    check("R4 tone cycles", on_c, L);
    check("R4 gap cycles", gap_c, L);
    check("R4 code", tone_code, 9);
    bus_rd(1'b1, r); check("R8 status after burst", r, 4'b1011);
    check("R10 irq released", irq_n, 1);
    bus_rd(1'b1, r); check("R10 status cleared", r, 4'b0010);

    // R6 / R7: write while busy ignored, ready low
    bus_wr(1'b0, 4'd3);
    idle(1);
    bus_rd(1'b1, r); check("R7 ready low in burst", r, 4'b0000);
    bus_wr(1'b0, 4'd12);
    check("R6 code unchanged", tone_code, 3);
    idle(2*L);
    check("R6 burst ended on time", irq_n, 0);
    check("R6 code still", tone_code, 3);
    bus_rd(1'b1, r);

    // R5: call-progress doubles both intervals
    bus_wr(1'b1, 4'b0111);
    measure(4'd5, on_c, gap_c);
    check("R5 tone cycles", on_c, 2*L);
    check("R5 gap cycles", gap_c, 2*L);
    bus_rd(1'b1, r);

    // R8: interrupts disabled
    bus_wr(1'b1, 4'b0001);
    bus_wr(1'b0, 4'd1);
    begin
      int low_seen = 0;
      for (int i = 0; i < 2*L + 4; i++) begin
        if (!irq_n) low_seen++;
        @(negedge clk);
      end
      check("R8 irq masked", low_seen, 0);
    end
    bus_rd(1'b1, r); check("R8 status masked", r, 4'b1010);

    // R9: receive path with interrupt
    bus_wr(1'b1, 4'b0100);
    @(negedge clk); rx_valid = 1'b1; rx_code = 4'd7;
    @(negedge clk); rx_valid = 1'b0;
    check("R9 irq on rx", irq_n, 0);
    bus_rd(1'b0, r); check("R9 rx data", r, 7);
    bus_rd(1'b1, r); check("R9 status", r, 4'b0111);
    check("R10 irq released rx", irq_n, 1);
    bus_wr(1'b1, 4'b0000);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); rx_valid = 1'b1; rx_code = 4'(15 - c);
      @(negedge clk); rx_valid = 1'b0;
      bus_rd(1'b0, r); check("R9 rx sweep", r, 15 - c);
      check("R9 no irq when masked", irq_n, 1);
    end
    bus_rd(1'b1, r);

    // R11: test routing of steering
    set_b(4'b0010);
    rx_steer = 1'b1; idle(1);
    check("R11 steer high", irq_n, 0);
    rx_steer = 1'b0; idle(1);
    check("R11 steer low", irq_n, 1);
    bus_wr(1'b1, 4'b0010);
    rx_steer = 1'b1; idle(1);
    check("R11 cp mode blocks test", irq_n, 1);
    rx_steer = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule